// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit sits beside an I2C bus engine and turns the engine's one-cycle event pulses into sticky status flags. The events are arbitration lost, NACK received, access ready, receive data ready, transmit data ready, stop condition detected and addressed as a target. Two live levels are shown beside the flags: bus busy and receive shift register full.

A mask register selects which flags may raise the single interrupt line. A read-only vector register returns a small code that names the most urgent pending, enabled event, so an interrupt handler can dispatch on one read. Flags are cleared by writing ones to the status register. The receive-ready flag also clears when the receive data register is read, and the transmit-ready flag clears when the transmit data register is written.

The register port is a simple synchronous write strobe with a combinational read mux. Mask sits at offset 0x04, status at 0x08 and vector at 0x28.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset the status event flags, the mask and the vector all read 0, and `irqOut` is low.
- R2: A one-cycle event pulse sets its status flag on the next clock edge, whatever the mask holds. Status bit positions: arbitration lost 0, NACK 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed-as-target 6.
- R3: A write to status (offset 0x08) clears each event flag whose data bit is 1 and leaves the others alone. If an event pulse arrives in the same cycle as the clear for its flag, the flag stays set.
- R4: A `rxDataRead` pulse clears status bit 3, and a `txDataWrite` pulse clears status bit 4. A new event in the same cycle wins.
- R5: Status bit 11 follows `lvlRxShiftFull` and bit 12 follows `lvlBusBusy` combinationally. Writes to those positions have no effect.
- R6: The mask register (offset 0x04) stores data bits 6..0, which use the same bit positions as the status flags. Bits 15..7 always read 0.
- R7: `irqOut` is high exactly when at least one status flag is set together with its mask bit.
- R8: The vector register (offset 0x28) reads code = bit position + 1 of the lowest-numbered flag that is both set and enabled. Codes run 1 arbitration lost, 2 NACK, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop, 7 addressed-as-target. It reads 0 when no enabled flag is pending.
- R9: Reads at any other offset return 0. Writes to the vector offset or to unmapped offsets change neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evArbLost | input | 1 | Arbitration lost pulse |
| evNack | input | 1 | NACK received pulse |
| evAccRdy | input | 1 | Access ready pulse |
| evRxRdy | input | 1 | Receive data ready pulse |
| evTxRdy | input | 1 | Transmit data ready pulse |
| evStop | input | 1 | Stop detected pulse |
| evAddrTgt | input | 1 | Addressed as target pulse |
| lvlBusBusy | input | 1 | Bus busy level |
| lvlRxShiftFull | input | 1 | Receive shift register full level |
| rxDataRead | input | 1 | Receive data register read pulse |
| txDataWrite | input | 1 | Transmit data register write pulse |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| irqOut | output | 1 | Interrupt request |

## Verification
Every flag, mask or clear change takes effect at the first rising edge that samples the pulse or strobe. Status, vector and `irqOut` therefore show the new value one cycle after the stimulus. The two level bits and all read data are combinational, so they are valid within the same cycle. The bench drives stimuli on the falling edge, holds them across exactly one rising edge, and reads back on the following falling edge. For level bits it reads a short settle delay after changing the input, with no clock edge in between.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_EVT = 7;
  localparam int DATA_W  = 16;

  // Flag positions; these also fix the priority order and the vector codes.
  localparam int BIT_ARB  = 0;
  localparam int BIT_NACK = 1;
  localparam int BIT_ARDY = 2;
  localparam int BIT_RX   = 3;
  localparam int BIT_TX   = 4;
  localparam int BIT_STOP = 5;
  localparam int BIT_TGT  = 6;
  localparam int BIT_RSF  = 11;
  localparam int BIT_BB   = 12;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_MASK   = 2'd1,
    RD_STATUS = 2'd2,
    RD_VECTOR = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrStatus;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OFS_MASK = 'h04,
  parameter int OFS_STAT = 'h08,
  parameter int OFS_VEC  = 'h28
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);

  logic hitMask, hitStat, hitVec;

  always_comb begin
    hitMask = (regAddr == A_MASK);
    hitStat = (regAddr == A_STAT);
    hitVec  = (regAddr == A_VEC);

    stb.wrMask   = regWrEn && hitMask;
    stb.wrStatus = regWrEn && hitStat;

    if (hitMask)      stb.rdSel = RD_MASK;
    else if (hitStat) stb.rdSel = RD_STATUS;
    else if (hitVec)  stb.rdSel = RD_VECTOR;
    else              stb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/i2c_irq_dp.sv
module i2c_irq_dp
  import i2c_irq_pkg::*;
#(
  parameter int EVT_N = NUM_EVT,
  parameter int DW    = DATA_W,
  parameter int RX_BIT = BIT_RX,
  parameter int TX_BIT = BIT_TX,
  parameter int RSF_BIT = BIT_RSF,
  parameter int BB_BIT  = BIT_BB
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       stb,
  input  logic [DW-1:0]    regWrData,
  input  logic [EVT_N-1:0] evPulse,
  input  logic             rxDataRead,
  input  logic             txDataWrite,
  input  logic             lvlBusBusy,
  input  logic             lvlRxShiftFull,
  output logic [EVT_N-1:0] flagQ,
  output logic [EVT_N-1:0] maskQ,
  output logic [DW-1:0]    vecCode,
  output logic [DW-1:0]    regRdData,
  output logic             irqOut
);
  localparam int CODE_W = $clog2(EVT_N + 1);

  logic [EVT_N-1:0] clrVec;
  logic [EVT_N-1:0] flagD;
  logic [EVT_N-1:0] pending;
  logic [CODE_W-1:0] codeSel;
  logic [DW-1:0] statusWord;

  // Per-flag clear sources and next state.
  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    logic sideClr;
    if (i == RX_BIT) begin : g_rx
      assign sideClr = rxDataRead;
    end else if (i == TX_BIT) begin : g_tx
      assign sideClr = txDataWrite;
    end else begin : g_none
      assign sideClr = 1'b0;
    end
    assign clrVec[i] = (stb.wrStatus && regWrData[i]) || sideClr;
    // A new event takes precedence over any clear in the same cycle.
    assign flagD[i]  = evPulse[i] || (flagQ[i] && !clrVec[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= flagD;
      if (stb.wrMask) maskQ <= regWrData[EVT_N-1:0];
    end
  end

  assign pending = flagQ & maskQ;
  assign irqOut  = |pending;

  // Lowest pending position wins; the code is position + 1.
  always_comb begin
    codeSel = '0;
    for (int k = EVT_N - 1; k >= 0; k--) begin
      if (pending[k]) codeSel = CODE_W'(k + 1);
    end
    vecCode = DW'(codeSel);
  end

  always_comb begin
    statusWord = '0;
    statusWord[EVT_N-1:0] = flagQ;
    statusWord[RSF_BIT]   = lvlRxShiftFull;
    statusWord[BB_BIT]    = lvlBusBusy;
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_MASK:   regRdData = DW'(maskQ);
      RD_STATUS: regRdData = statusWord;
      RD_VECTOR: regRdData = vecCode;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evArbLost,
  input  logic              evNack,
  input  logic              evAccRdy,
  input  logic              evRxRdy,
  input  logic              evTxRdy,
  input  logic              evStop,
  input  logic              evAddrTgt,
  input  logic              lvlBusBusy,
  input  logic              lvlRxShiftFull,
  input  logic              rxDataRead,
  input  logic              txDataWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  output logic              irqOut
);
  regStrobe_t         stb;
  logic [NUM_EVT-1:0] evPulse;
  logic [NUM_EVT-1:0] flagQ;
  logic [NUM_EVT-1:0] maskQ;
  logic [DW-1:0]      vecCode;

  always_comb begin
    evPulse           = '0;
    evPulse[BIT_ARB]  = evArbLost;
    evPulse[BIT_NACK] = evNack;
    evPulse[BIT_ARDY] = evAccRdy;
    evPulse[BIT_RX]   = evRxRdy;
    evPulse[BIT_TX]   = evTxRdy;
    evPulse[BIT_STOP] = evStop;
    evPulse[BIT_TGT]  = evAddrTgt;
  end

  i2c_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .stb     (stb)
  );

  i2c_irq_dp #(.DW(DW)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .regWrData      (regWrData),
    .evPulse        (evPulse),
    .rxDataRead     (rxDataRead),
    .txDataWrite    (txDataWrite),
    .lvlBusBusy     (lvlBusBusy),
    .lvlRxShiftFull (lvlRxShiftFull),
    .flagQ          (flagQ),
    .maskQ          (maskQ),
    .vecCode        (vecCode),
    .regRdData      (regRdData),
    .irqOut         (irqOut)
  );
endmodule

// File: rtl/i2c_irq_vector_chk.sv
module i2c_irq_vector_chk #(
  parameter int ADDR_W = 8,
  parameter int DW     = 16,
  parameter int EVT_N  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              evNack,
  input logic              evStop,
  input logic              evRxRdy,
  input logic              rxDataRead,
  input logic              lvlBusBusy,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DW-1:0]     regWrData,
  input logic [DW-1:0]     regRdData,
  input logic [EVT_N-1:0] flagQ,
  input logic [DW-1:0]     vecCode,
  input logic              irqOut
);
  // R2
  nack_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evNack |=> flagQ[1]);

  // R3
  stop_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'('h08) && regWrData[5] && !evStop) |=> !flagQ[5]);

  // R4
  rx_read_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDataRead && !evRxRdy) |=> !flagQ[3]);

  // R5
  busy_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'('h08)) |-> (regRdData[12] == lvlBusBusy));

  // R6
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'('h04)) |-> (regRdData[DW-1:EVT_N] == '0));

  // R7
  irq_has_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (vecCode != '0));

  // R8
  vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecCode <= DW'(EVT_N));
endmodule

bind i2c_irq_vector i2c_irq_vector_chk #(.ADDR_W(ADDR_W), .DW(DW), .EVT_N(i2c_irq_pkg::NUM_EVT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evNack     (evNack),
  .evStop     (evStop),
  .evRxRdy    (evRxRdy),
  .rxDataRead (rxDataRead),
  .lvlBusBusy (lvlBusBusy),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .flagQ      (flagQ),
  .vecCode    (vecCode),
  .irqOut     (irqOut)
);

// File: tb/i2c_irq_vector_tb.sv
module i2c_irq_vector_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evArbLost = 0, evNack = 0, evAccRdy = 0, evRxRdy = 0;
  logic evTxRdy = 0, evStop = 0, evAddrTgt = 0;
  logic lvlBusBusy = 0, lvlRxShiftFull = 0;
  logic rxDataRead = 0, txDataWrite = 0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = 16'h0000;
  logic [15:0] regRdData;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  localparam logic [7:0] A_MASK = 8'h04;
  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_VEC  = 8'h28;

  always #10 clk = ~clk;

  i2c_irq_vector u_dut (
    .clk(clk), .rstN(rstN),
    .evArbLost(evArbLost), .evNack(evNack), .evAccRdy(evAccRdy),
    .evRxRdy(evRxRdy), .evTxRdy(evTxRdy), .evStop(evStop), .evAddrTgt(evAddrTgt),
    .lvlBusBusy(lvlBusBusy), .lvlRxShiftFull(lvlRxShiftFull),
    .rxDataRead(rxDataRead), .txDataWrite(txDataWrite),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  // Drive events (bit i = status position i) for one cycle.
  task automatic pulseEv(input logic [6:0] ev);
    @(negedge clk);
    {evAddrTgt, evStop, evTxRdy, evRxRdy, evAccRdy, evNack, evArbLost} = ev;
    @(negedge clk);
    {evAddrTgt, evStop, evTxRdy, evRxRdy, evAccRdy, evNack, evArbLost} = '0;
  endtask

  // Register write, optionally with events in the same cycle.
  task automatic wrReg(input logic [7:0] a, input logic [15:0] d, input logic [6:0] ev);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    {evAddrTgt, evStop, evTxRdy, evRxRdy, evAccRdy, evNack, evArbLost} = ev;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    {evAddrTgt, evStop, evTxRdy, evRxRdy, evAccRdy, evNack, evArbLost} = '0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic clearAll();
    wrReg(A_STAT, 16'h007F, 7'h00);
    wrReg(A_MASK, 16'h0000, 7'h00);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rdReg(A_STAT, d); check("R1 status", d, 16'h0000);
    rdReg(A_MASK, d); check("R1 mask", d, 16'h0000);
    rdReg(A_VEC, d);  check("R1 vector", d, 16'h0000);
    check("R1 irq", {15'd0, irqOut}, 16'h0000);
  endtask

  task automatic t_set();
    logic [15:0] d;
    for (int i = 0; i < 7; i++) begin
      pulseEv(7'(1 << i));
      rdReg(A_STAT, d); check("R2 single flag", d, 16'(1 << i));
      check("R7 masked off irq", {15'd0, irqOut}, 16'h0000);
      rdReg(A_VEC, d); check("R8 masked off vector", d, 16'h0000);
      wrReg(A_STAT, 16'h007F, 7'h00);
    end
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    pulseEv(7'h24);
    wrReg(A_STAT, 16'h0000, 7'h00);
    rdReg(A_STAT, d); check("R3 write zero keeps", d, 16'h0024);
    wrReg(A_STAT, 16'h0004, 7'h00);
    rdReg(A_STAT, d); check("R3 clear one bit", d, 16'h0020);
    wrReg(A_STAT, 16'h0020, 7'h20);
    rdReg(A_STAT, d); check("R3 event beats clear", d, 16'h0020);
    wrReg(A_STAT, 16'h0020, 7'h00);
    rdReg(A_STAT, d); check("R3 cleared", d, 16'h0000);
  endtask

  task automatic t_rxtx();
    logic [15:0] d;
    pulseEv(7'h18);
    @(negedge clk); rxDataRead = 1'b1;
    @(negedge clk); rxDataRead = 1'b0;
    rdReg(A_STAT, d); check("R4 rx read clears bit3", d, 16'h0010);
    @(negedge clk); txDataWrite = 1'b1;
    @(negedge clk); txDataWrite = 1'b0;
    rdReg(A_STAT, d); check("R4 tx write clears bit4", d, 16'h0000);
    @(negedge clk); rxDataRead = 1'b1; evRxRdy = 1'b1;
    @(negedge clk); rxDataRead = 1'b0; evRxRdy = 1'b0;
    rdReg(A_STAT, d); check("R4 new rx event wins", d, 16'h0008);
    clearAll();
  endtask

  task automatic t_levels();
    logic [15:0] d;
    @(negedge clk); lvlBusBusy = 1'b1;
    rdReg(A_STAT, d); check("R5 busy live", d, 16'h1000);
    lvlRxShiftFull = 1'b1;
    rdReg(A_STAT, d); check("R5 shift full live", d, 16'h1800);
    wrReg(A_STAT, 16'h1800, 7'h00);
    rdReg(A_STAT, d); check("R5 write ignored", d, 16'h1800);
    lvlBusBusy = 1'b0; lvlRxShiftFull = 1'b0;
    rdReg(A_STAT, d); check("R5 levels drop", d, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wrReg(A_MASK, 16'hFFFF, 7'h00);
    rdReg(A_MASK, d); check("R6 upper bits zero", d, 16'h007F);
    wrReg(A_MASK, 16'h0015, 7'h00);
    rdReg(A_MASK, d); check("R6 pattern", d, 16'h0015);
    clearAll();
  endtask

  task automatic t_irq();
    logic [15:0] d;
    pulseEv(7'h02);
    check("R7 flag without mask", {15'd0, irqOut}, 16'h0000);
    wrReg(A_MASK, 16'h0002, 7'h00);
    check("R7 flag with mask", {15'd0, irqOut}, 16'h0001);
    wrReg(A_MASK, 16'h007D, 7'h00);
    check("R7 other mask bits", {15'd0, irqOut}, 16'h0000);
    rdReg(A_VEC, d); check("R8 nothing enabled", d, 16'h0000);
    clearAll();
  endtask

  task automatic t_prio();
    logic [15:0] d;
    pulseEv(7'h7F);
    wrReg(A_MASK, 16'h007E, 7'h00);
    rdReg(A_VEC, d); check("R8 bit0 masked", d, 16'h0002);
    wrReg(A_MASK, 16'h007F, 7'h00);
    for (int k = 0; k < 7; k++) begin
      rdReg(A_VEC, d); check("R8 priority code", d, 16'(k + 1));
      wrReg(A_STAT, 16'(1 << k), 7'h00);
    end
    rdReg(A_VEC, d); check("R8 empty vector", d, 16'h0000);
    check("R7 irq drops", {15'd0, irqOut}, 16'h0000);
    clearAll();
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    pulseEv(7'h41);
    wrReg(A_MASK, 16'h0040, 7'h00);
    wrReg(A_VEC, 16'hFFFF, 7'h00);
    wrReg(8'h00, 16'hFFFF, 7'h00);
    wrReg(8'h0C, 16'hFFFF, 7'h00);
    rdReg(A_STAT, d); check("R9 status untouched", d, 16'h0041);
    rdReg(A_MASK, d); check("R9 mask untouched", d, 16'h0040);
    rdReg(A_VEC, d); check("R9 vector unchanged", d, 16'h0007);
    rdReg(8'h00, d); check("R9 unmapped read", d, 16'h0000);
    rdReg(8'h30, d); check("R9 unmapped read 2", d, 16'h0000);
    clearAll();
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_w1c();
    t_rxtx();
    t_levels();
    t_mask();
    t_irq();
    t_prio();
    t_unmapped();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule